// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block produces the serial-clock timing for an I2C master from its peripheral clock. An 11-bit period select is assembled from two configuration inputs. Five low bits come from the control input and six high bits come from an extension input. A mode bit chooses between symmetric standard-mode timing and fast-mode timing, where the low phase is about twice the high phase. An enable bit starts and stops the generator.

The block drives an active-high `scl_low` request: the pad pulls SCL low while it is set. The block reads back the real line level on `scl_in`. A slave that holds SCL low during the high phase freezes the high-phase count, which gives clock stretching. The byte controller receives four one-cycle strobes:
- one when SCL falls;
- one when SCL rises;
- a bit-tick in the middle of each high phase, for data sampling;
- a data-change point inside each low phase, placed by a coarse peripheral-clock range code.

Start/stop sequencing and data shifting belong to other blocks.

Top module: `scl_timer`

## Requirements
- R1: The period select N is {ext_reg[5:0], ctl_reg[4:0]}, giving 11 bits. ctl_reg[5] is the enable and ctl_reg[6] selects fast mode (1) or standard mode (0).
- R2: In standard mode, the low phase lasts N+2 clocks and the high phase lasts N+2 clocks, so the SCL period is 2(N+1)+2 clocks.
- R3: In fast mode, the low phase lasts N+2 clocks and the high phase lasts floor((N+1)/2)+1 clocks, so the period is about 1.5(N+1)+2 clocks.
- R4: During reset, and in the clock after any edge that samples the enable low, `scl_low` and every strobe are 0. Disabling in mid-phase returns the generator to idle.
- R5: The first clock edge that samples the enable high starts a low phase, with `fall_p` set for that clock.
- R6: `fall_p` is high for exactly the first clock of each low phase. `rise_p` is high for exactly the first clock of each high phase. The two are never high together.
- R7: While the generator releases SCL but `scl_in` reads 0, the high-phase count is frozen. Each stretched clock lengthens the high phase by one clock.
- R8: `bit_tick` is a one-clock pulse in high-phase clock floor(H/2)+1, where H is the high-phase length and clock 1 carries `rise_p`. It is only asserted while `scl_in` is 1.
- R9: `data_chg` is a one-clock pulse in low-phase clock min(F, L-1)+1, where F is freq_code[3:0], L is the low-phase length and clock 1 carries `fall_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_reg | input | 7 | [4:0] low select bits, [5] enable, [6] fast mode |
| ext_reg | input | 6 | High select bits |
| freq_code | input | 4 | Peripheral-clock range code, floor(Fpclk/20 MHz)+1 |
| scl_in | input | 1 | Sampled SCL line level |
| scl_low | output | 1 | Request to pull SCL low |
| fall_p | output | 1 | First clock of a low phase |
| rise_p | output | 1 | First clock of a high phase |
| bit_tick | output | 1 | Mid-high-phase sampling strobe |
| data_chg | output | 1 | Data-change point within the low phase |

## Verification
The assertions check on every cycle the relationships that need no knowledge of N:
- strobe exclusivity and the phase each strobe belongs to;
- quiet outputs after a disable;
- a low phase starting as soon as the generator is enabled;
- SCL staying released while a slave stretches it.

Only the bench's scenarios can show the phase lengths that N and the mode produce, and where the tick and data-change points fall. The bench also covers the extreme selects, including the full 11-bit value and the shortest fast-mode high phase. The exact growth of the high phase under stretching is likewise shown only by a scenario.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int LO_W   = 5,
  parameter int HI_W   = 6,
  parameter int FREQ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W+1:0]   ctl_reg,
  input  logic [HI_W-1:0]   ext_reg,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic              scl_in,
  output logic              scl_low,
  output logic              fall_p,
  output logic              rise_p,
  output logic              bit_tick,
  output logic              data_chg
);
  localparam int SEL_W = LO_W + HI_W;
  localparam int CNT_W = SEL_W + 1;

  logic             en, fast;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] sel_p1, low_len, high_len, low_last, high_last, mid, hold_pt, freq_x;
  logic             active, phase_hi;
  logic [CNT_W-1:0] cnt;

  assign en       = ctl_reg[LO_W];
  assign fast     = ctl_reg[LO_W+1];
  assign sel      = {ext_reg, ctl_reg[LO_W-1:0]};
  assign sel_p1   = {1'b0, sel} + CNT_W'(1);
  assign low_len  = sel_p1 + CNT_W'(1);
  assign high_len = fast ? (sel_p1 >> 1) + CNT_W'(1) : low_len;
  assign low_last  = low_len - CNT_W'(1);
  assign high_last = high_len - CNT_W'(1);
  assign mid       = high_len >> 1;
  assign freq_x    = CNT_W'(freq_code);
  assign hold_pt   = (freq_x < low_last) ? freq_x : low_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase_hi <= 1'b1;
      cnt      <= '0;
      fall_p   <= 1'b0;
      rise_p   <= 1'b0;
    end else begin
      fall_p <= 1'b0;
      rise_p <= 1'b0;
      if (!en) begin
        active   <= 1'b0;
        phase_hi <= 1'b1;
        cnt      <= '0;
      end else if (!active) begin
        active   <= 1'b1;
        phase_hi <= 1'b0;
        cnt      <= '0;
        fall_p   <= 1'b1;
      end else if (!phase_hi) begin
        if (cnt >= low_last) begin
          phase_hi <= 1'b1;
          cnt      <= '0;
          rise_p   <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if (scl_in) begin
        if (cnt >= high_last) begin
          phase_hi <= 1'b0;
          cnt      <= '0;
          fall_p   <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign scl_low  = active & ~phase_hi;
  assign bit_tick = active & phase_hi & scl_in & (cnt == mid);
  assign data_chg = scl_low & (cnt == hold_pt);
endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic active,
  input logic scl_in,
  input logic scl_low,
  input logic fall_p,
  input logic rise_p,
  input logic bit_tick,
  input logic data_chg
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_p, rise_p}));
  p_fall_in_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_p |-> scl_low);
  p_rise_in_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |-> !scl_low);
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_low && !fall_p && !rise_p && !bit_tick && !data_chg));
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !active) |=> fall_p);
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active && !scl_low && !scl_in) |=> !scl_low);
  p_tick_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (!scl_low && scl_in));
  p_dchg_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_chg |-> scl_low);
endmodule

bind scl_timer scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .active(active), .scl_in(scl_in),
  .scl_low(scl_low), .fall_p(fall_p), .rise_p(rise_p),
  .bit_tick(bit_tick), .data_chg(data_chg)
);

// File: tb/scl_timer_test.sv
module scl_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ctl_reg = '0;
  logic [5:0] ext_reg = '0;
  logic [3:0] freq_code = '0;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_low, fall_p, rise_p, bit_tick, data_chg;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;
  assign scl_in = ~scl_low & ~stretch;

  scl_timer uut (
    .clk(clk), .rst_n(rst_n), .ctl_reg(ctl_reg), .ext_reg(ext_reg),
    .freq_code(freq_code), .scl_in(scl_in), .scl_low(scl_low),
    .fall_p(fall_p), .rise_p(rise_p), .bit_tick(bit_tick), .data_chg(data_chg)
  );

  // fast, ext, lo, freq, expected low, high, tick index, data-change index
  localparam int NV = 8;
  localparam int VEC [NV][8] = '{
    '{0, 0,  0,  0,    2,    2,    2,  1},
    '{0, 0,  5,  3,    7,    7,    4,  4},
    '{0, 1,  3, 11,   37,   37,   19, 12},
    '{0, 0, 31,  5,   33,   33,   17,  6},
    '{0, 63, 31, 1, 2049, 2049, 1025,  2},
    '{1, 0,  0,  2,    2,    1,    1,  2},
    '{1, 0,  6,  0,    8,    4,    3,  1},
    '{1, 2, 31, 15,   97,   49,   25, 16}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int sn, output int lo_len, output int hi_len,
                         output int tick_at, output int dchg_at, output int rise_ok,
                         output int fall_ok);
    int idx;
    lo_len = 0; hi_len = 0; tick_at = 0; dchg_at = 0;
    idx = 1;
    while (scl_low && idx < 5000) begin
      if (data_chg && dchg_at == 0) dchg_at = idx;
      @(negedge clk);
      idx++;
    end
    lo_len = idx - 1;
    rise_ok = rise_p;
    idx = 1;
    stretch = (sn > 0);
    #1;
    while (!scl_low && idx < 5000) begin
      if (bit_tick && tick_at == 0) tick_at = idx;
      @(negedge clk);
      idx++;
      stretch = (idx <= sn);
      #1;
    end
    stretch = 1'b0;
    hi_len = idx - 1;
    fall_ok = fall_p;
  endtask

  task automatic start_gen(input int fast, input int ext, input int lo, input int fq);
    ctl_reg = 7'(lo);
    ctl_reg[5] = 1'b0;
    ext_reg = 6'(ext);
    freq_code = 4'(fq);
    repeat (3) @(negedge clk);
    ctl_reg[6] = fast[0];
    ctl_reg[5] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int l, h, t, d, ro, fo;
    repeat (2) @(negedge clk);
    check("R4 reset scl_low", int'(scl_low), 0);
    check("R4 reset strobes", int'({fall_p, rise_p, bit_tick, data_chg}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      start_gen(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      check("R5 fall strobe on enable", int'(fall_p), 1);
      measure(0, l, h, t, d, ro, fo);
      check(VEC[v][0] ? "R3 low length" : "R2 low length (R1 select)", l, VEC[v][4]);
      check(VEC[v][0] ? "R3 high length" : "R2 high length", h, VEC[v][5]);
      check("R8 tick position", t, VEC[v][6]);
      check("R9 data change position", d, VEC[v][7]);
      check("R6 rise strobe", ro, 1);
      check("R6 fall strobe next low", fo, 1);
    end

    // stretching: std N=5, hold SCL low for the first 5 high clocks
    start_gen(0, 0, 5, 3);
    measure(5, l, h, t, d, ro, fo);
    check("R7 stretched high length", h, 12);
    check("R7 stretched tick position", t, 9);
    check("R7 low unchanged", l, 7);

    // mid-phase disable
    start_gen(0, 0, 20, 0);
    repeat (4) @(negedge clk);
    check("R4 running before disable", int'(scl_low), 1);
    ctl_reg[5] = 1'b0;
    @(negedge clk);
    check("R4 disabled scl_low", int'(scl_low), 0);
    for (int k = 0; k < 30; k++) begin
      if (scl_low | fall_p | rise_p | bit_tick | data_chg)
        check("R4 idle stays quiet", 1, 0);
      @(negedge clk);
    end
    check("R4 idle after 30 clocks", int'({scl_low, fall_p, rise_p, bit_tick, data_chg}), 0);
    ctl_reg[5] = 1'b1;
    @(negedge clk);
    check("R5 restart fall strobe", int'(fall_p), 1);
    check("R5 restart scl_low", int'(scl_low), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule